// File: doc/BRIEF.md
# Bus-Master DMA Channel Status and Table Pointer Registers

This block holds the per-channel status byte and the descriptor-table base pointer of a bus-master disk DMA controller. The DMA engine reports its milestones to the block as one-cycle event pulses: a transfer was started, a start was withdrawn, the final region of the table finished, a descriptor that requests an interrupt finished, or a bus abort happened. The block turns these pulses into sticky flags that software reads and then clears by writing ones.

The raw device interrupt line is also watched. Only a low-to-high change on that line sets the interrupt flag, so clearing the flag while the line stays high leaves it clear until the line falls and rises again. Two general-purpose capability bits are kept for software and have no effect on hardware. The pointer register stores a word-aligned table address.

The register port is a plain offset, write data and write enable interface, with a read data bus decoded without a clock. Register updates take effect on the clock edge that samples the write or event.

Top module: `dma_bm_status`

## Requirements
- R1: After synchronous reset the status byte (offset 2) reads 00h and the table pointer (offset 4) reads 00000000h.
- R2: A rising edge of the device interrupt input, detected by comparing it with its value one clock earlier (that earlier value is 0 out of reset), sets status bit 2 on that clock edge.
- R3: Writing status with bit 2 set clears bit 2; if the interrupt input stays high, bit 2 remains 0 until the input falls and rises again.
- R4: A bus-abort event sets status bit 1; writing status with bit 1 set clears it.
- R5: A start event sets status bit 0; a start-withdrawn event or an end-of-table completion event clears it; if a start event and a clearing event occur in the same cycle, bit 0 ends set.
- R6: A completion event for a descriptor with its interrupt request set sets status bit 7; writing status with bit 7 set clears it.
- R7: When a set event and a software clear write target the same flag (bit 7, 2 or 1) in the same cycle, the flag ends set.
- R8: Writing 0 to bits 7, 2 or 1 leaves them unchanged; writes to bit 0 and to bits 4:3 have no effect; bits 4:3 always read 0.
- R9: Status bits 6 and 5 are plain read/write bits that hold the last value written to them.
- R10: The table pointer stores write data bits 31:2; bits 1:0 always read 0.
- R11: Reads at offsets other than 2 and 4 return 0, and writes at those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_off | input | 3 | Byte offset of the register accessed |
| wr_en | input | 1 | Write enable for the register at reg_off |
| wr_data | input | 32 | Write data; status uses bits 7:0 |
| rd_data | output | 32 | Read data for the register at reg_off, right aligned |
| ev_start_set | input | 1 | Pulse: start bit written by software |
| ev_start_clr | input | 1 | Pulse: start bit cleared by software |
| ev_eot_done | input | 1 | Pulse: last transfer of end-of-table region finished |
| ev_desc_irq | input | 1 | Pulse: descriptor with interrupt request finished |
| ev_bus_abort | input | 1 | Pulse: target or master abort on a data transfer |
| dev_irq | input | 1 | Raw device interrupt line, already synchronous to clk |

## Verification
The assertions assume every event input is a single-cycle pulse synchronous to the clock and that the device interrupt line has already been brought into the clock domain, so an edge on it is one that the register itself sees between two samples. They also assume that write data is meaningful only while the write enable is high. The stimulus changes every input only at the falling clock edge, holds each event for exactly one cycle, and performs reads with the write enable low so that a read never overlaps an update of the same register.

// File: rtl/dma_bm_status_pkg.sv
package dma_bm_status_pkg;

    localparam int unsigned OFF_W      = 3;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned STAT_W     = 8;

    localparam logic [OFF_W-1:0] OFF_STATUS = 3'h2;
    localparam logic [OFF_W-1:0] OFF_TABPTR = 3'h4;

    // Bit positions inside the status byte (software decodes these)
    localparam int unsigned POS_DESC_IRQ = 7;
    localparam int unsigned POS_CAP_HI   = 6;
    localparam int unsigned POS_CAP_LO   = 5;
    localparam int unsigned POS_IRQ      = 2;
    localparam int unsigned POS_ERR      = 1;
    localparam int unsigned POS_ACT      = 0;

    localparam int unsigned N_STICKY = 3;

    typedef struct packed {
        logic       desc_irq;
        logic [1:0] cap;
        logic [1:0] rsvd;
        logic       irq;
        logic       err;
        logic       act;
    } status_t;

    typedef struct packed {
        logic start_set;
        logic start_clr;
        logic eot_done;
        logic desc_irq;
        logic bus_abort;
    } dma_evt_t;

    // Position of each sticky flag, indexed by generate lane
    function automatic int unsigned sticky_pos(input int unsigned lane);
        case (lane)
            0:       return POS_DESC_IRQ;
            1:       return POS_IRQ;
            default: return POS_ERR;
        endcase
    endfunction

    // A write of 1 to a given position of the status byte
    function automatic logic one_written(input logic we,
                                         input logic [STAT_W-1:0] data,
                                         input int unsigned pos);
        return we && data[pos];
    endfunction

endpackage

// File: rtl/dma_bm_irq_edge.sv
module dma_bm_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic rise_o
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= line_i;
    end

    assign rise_o = line_i && !line_q;
endmodule

// File: rtl/dma_bm_sticky.sv
module dma_bm_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/dma_bm_active.sv
module dma_bm_active (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic stop_i,
    input  logic finish_i,
    output logic busy_o
);
    always_ff @(posedge clk) begin
        if (rst)                    busy_o <= 1'b0;
        else if (go_i)              busy_o <= 1'b1;
        else if (stop_i || finish_i) busy_o <= 1'b0;
    end
endmodule

// File: rtl/dma_bm_status.sv
module dma_bm_status
    import dma_bm_status_pkg::*;
#(
    parameter int unsigned ADDR_W  = OFF_W,
    parameter int unsigned DATA_W  = BUS_W,
    parameter int unsigned ALIGN_B = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_start_set,
    input  logic              ev_start_clr,
    input  logic              ev_eot_done,
    input  logic              ev_desc_irq,
    input  logic              ev_bus_abort,
    input  logic              dev_irq
);
    localparam int unsigned PTR_HI = DATA_W - 1;

    dma_evt_t             evt;
    status_t              status_q;
    logic                 irq_rise;
    logic                 wr_stat;
    logic                 wr_ptr;
    logic [STAT_W-1:0]    wbyte;
    logic [N_STICKY-1:0]  sticky_set;
    logic [N_STICKY-1:0]  sticky_q;
    logic [1:0]           cap_q;
    logic                 act_q;
    logic [PTR_HI:ALIGN_B] ptr_q;

    assign evt = '{start_set: ev_start_set, start_clr: ev_start_clr,
                   eot_done: ev_eot_done, desc_irq: ev_desc_irq,
                   bus_abort: ev_bus_abort};

    assign wr_stat = wr_en && (reg_off == ADDR_W'(OFF_STATUS));
    assign wr_ptr  = wr_en && (reg_off == ADDR_W'(OFF_TABPTR));
    assign wbyte   = wr_data[STAT_W-1:0];

    dma_bm_irq_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (dev_irq),
        .rise_o (irq_rise)
    );

    // Set sources in lane order: descriptor irq, device irq, error
    assign sticky_set = {evt.bus_abort, irq_rise, evt.desc_irq};

    generate
        for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
            dma_bm_sticky u_flag (
                .clk    (clk),
                .rst    (rst),
                .set_i  (sticky_set[g]),
                .clr_i  (one_written(wr_stat, wbyte, sticky_pos(g))),
                .flag_o (sticky_q[g])
            );
        end
    endgenerate

    dma_bm_active u_act (
        .clk      (clk),
        .rst      (rst),
        .go_i     (evt.start_set),
        .stop_i   (evt.start_clr),
        .finish_i (evt.eot_done),
        .busy_o   (act_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            ptr_q <= '0;
        end else begin
            if (wr_stat) cap_q <= {wbyte[POS_CAP_HI], wbyte[POS_CAP_LO]};
            if (wr_ptr)  ptr_q <= wr_data[PTR_HI:ALIGN_B];
        end
    end

    always_comb begin
        status_q          = '0;
        status_q.desc_irq = sticky_q[0];
        status_q.irq      = sticky_q[1];
        status_q.err      = sticky_q[2];
        status_q.cap      = cap_q;
        status_q.act      = act_q;
    end

    always_comb begin
        rd_data = '0;
        if (reg_off == ADDR_W'(OFF_STATUS))
            rd_data[STAT_W-1:0] = status_q;
        else if (reg_off == ADDR_W'(OFF_TABPTR))
            rd_data = {ptr_q, {ALIGN_B{1'b0}}};
    end
endmodule

// File: rtl/dma_bm_status_chk.sv
module dma_bm_status_chk
    import dma_bm_status_pkg::*;
#(
    parameter int unsigned ADDR_W = OFF_W,
    parameter int unsigned DATA_W = BUS_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_off,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              ev_start_set,
    input logic              ev_start_clr,
    input logic              ev_eot_done,
    input logic              ev_desc_irq,
    input logic              ev_bus_abort,
    input logic              dev_irq,
    input logic [7:0]        stat
);
    logic stat_wr;
    assign stat_wr = wr_en && (reg_off == ADDR_W'(OFF_STATUS));

    AST_IRQ_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> stat[2]); // R2

    AST_IRQ_NO_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
        !stat[2] && !$rose(dev_irq) && !$past(rst) |=> !stat[2]); // R3

    AST_ABORT_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        ev_bus_abort |=> stat[1]); // R4

    AST_START_SETS_ACT: assert property (@(posedge clk) disable iff (rst)
        ev_start_set |=> stat[0]); // R5

    AST_STOP_CLEARS_ACT: assert property (@(posedge clk) disable iff (rst)
        (ev_start_clr || ev_eot_done) && !ev_start_set |=> !stat[0]); // R5

    AST_DESC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ev_desc_irq |=> stat[7]); // R6

    AST_ZERO_WRITE_KEEPS_ERR: assert property (@(posedge clk) disable iff (rst)
        stat_wr && !wr_data[1] && stat[1] |=> stat[1]); // R8

    AST_ACT_IGNORES_WRITE: assert property (@(posedge clk) disable iff (rst)
        stat_wr && !ev_start_set && !ev_start_clr && !ev_eot_done
        |=> stat[0] == $past(stat[0])); // R8
endmodule

bind dma_bm_status dma_bm_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_off      (reg_off),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ev_start_set (ev_start_set),
    .ev_start_clr (ev_start_clr),
    .ev_eot_done  (ev_eot_done),
    .ev_desc_irq  (ev_desc_irq),
    .ev_bus_abort (ev_bus_abort),
    .dev_irq      (dev_irq),
    .stat         (status_q)
);

// File: tb/dma_bm_status_test.sv
`timescale 1ns/1ps
module dma_bm_status_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_off = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_start_set = 1'b0, ev_start_clr = 1'b0, ev_eot_done = 1'b0;
    logic        ev_desc_irq = 1'b0, ev_bus_abort = 1'b0;
    logic        dev_irq = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]  off;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    dma_bm_status uut (
        .clk(clk), .rst(rst), .reg_off(reg_off), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .ev_start_set(ev_start_set), .ev_start_clr(ev_start_clr),
        .ev_eot_done(ev_eot_done), .ev_desc_irq(ev_desc_irq),
        .ev_bus_abort(ev_bus_abort), .dev_irq(dev_irq)
    );

    // Monitor: compares queued expectations shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: offset %0d read %08h expected %08h",
                             it.tag, it.off, rd_data, it.exp);
                end
            end
        end
    end

    task automatic quiet();
        wr_en = 1'b0; ev_start_set = 1'b0; ev_start_clr = 1'b0;
        ev_eot_done = 1'b0; ev_desc_irq = 1'b0; ev_bus_abort = 1'b0;
    endtask

    // Driver: one-cycle stimulus; evt = {start_set,start_clr,eot,desc,abort}
    task automatic drive(input logic [4:0] evt, input logic we,
                         input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        quiet();
        {ev_start_set, ev_start_clr, ev_eot_done, ev_desc_irq, ev_bus_abort} = evt;
        wr_en = we; reg_off = off; wr_data = d;
    endtask

    task automatic wr(input logic [2:0] off, input logic [31:0] d);
        drive(5'b0, 1'b1, off, d);
    endtask

    task automatic pulse(input logic [4:0] evt);
        drive(evt, 1'b0, 3'd2, 32'h0);
    endtask

    task automatic rd(input logic [2:0] off, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        quiet();
        reg_off = off;
        it.off = off; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic line(input logic v);
        @(negedge clk);
        quiet();
        dev_irq = v;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd2, 32'h00, "R1 status");
        rd(3'd4, 32'h0, "R1 pointer");

        // R2 rising edge sets irq
        line(1'b1);
        rd(3'd2, 32'h04, "R2 edge");
        // R3 clear while line high stays clear
        wr(3'd2, 32'h04);
        rd(3'd2, 32'h00, "R3 cleared");
        rd(3'd2, 32'h00, "R3 held high");
        rd(3'd2, 32'h00, "R3 held high 2");
        line(1'b0);
        rd(3'd2, 32'h00, "R3 line low");
        line(1'b1);
        rd(3'd2, 32'h04, "R3 new edge");
        line(1'b0);
        wr(3'd2, 32'h04);
        rd(3'd2, 32'h00, "R3 cleared low");

        // R4 error flag
        pulse(5'b00001);
        rd(3'd2, 32'h02, "R4 abort");
        wr(3'd2, 32'h00);
        rd(3'd2, 32'h02, "R8 zero write keeps");
        wr(3'd2, 32'h60);
        rd(3'd2, 32'h62, "R9 caps with err");
        wr(3'd2, 32'h02);
        rd(3'd2, 32'h00, "R4 clear");

        // R6 descriptor interrupt flag
        pulse(5'b00010);
        rd(3'd2, 32'h80, "R6 set");
        wr(3'd2, 32'h80);
        rd(3'd2, 32'h00, "R6 clear");

        // R5 active flag
        pulse(5'b10000);
        rd(3'd2, 32'h01, "R5 start");
        wr(3'd2, 32'h01);
        rd(3'd2, 32'h01, "R8 act write ignored");
        pulse(5'b01000);
        rd(3'd2, 32'h00, "R5 start cleared");
        pulse(5'b10000);
        pulse(5'b00100);
        rd(3'd2, 32'h00, "R5 end of table");
        pulse(5'b11000);
        rd(3'd2, 32'h01, "R5 start wins");
        pulse(5'b00100);
        rd(3'd2, 32'h00, "R5 idle again");

        // R7 set beats clear in same cycle
        pulse(5'b00001);
        drive(5'b00001, 1'b1, 3'd2, 32'h02);
        rd(3'd2, 32'h02, "R7 err set wins");
        drive(5'b00010, 1'b1, 3'd2, 32'h80);
        rd(3'd2, 32'h82, "R7 desc set wins");
        line(1'b1);
        @(negedge clk); quiet(); wr_en = 1'b1; reg_off = 3'd2; wr_data = 32'h04; dev_irq = 1'b0;
        line(1'b1);
        drive(5'b0, 1'b1, 3'd2, 32'h04);
        rd(3'd2, 32'h82, "R3 clear while high");
        line(1'b0);
        drive(5'b0, 1'b1, 3'd2, 32'h82);
        rd(3'd2, 32'h00, "R7 cleanup");

        // R8 reserved bits
        wr(3'd2, 32'h18);
        rd(3'd2, 32'h00, "R8 reserved");
        // R9 caps
        wr(3'd2, 32'h20);
        rd(3'd2, 32'h20, "R9 low cap");
        wr(3'd2, 32'h40);
        rd(3'd2, 32'h40, "R9 high cap");

        // R10 pointer alignment
        wr(3'd4, 32'hDEADBEEF);
        rd(3'd4, 32'hDEADBEEC, "R10 ptr");
        wr(3'd4, 32'h12345677);
        rd(3'd4, 32'h12345674, "R10 ptr 2");

        // R11 unmapped offsets
        wr(3'd0, 32'hFFFFFFFF);
        wr(3'd6, 32'hFFFFFFFF);
        rd(3'd0, 32'h0, "R11 off0");
        rd(3'd6, 32'h0, "R11 off6");
        rd(3'd2, 32'h40, "R11 status intact");
        rd(3'd4, 32'h12345674, "R11 ptr intact");

        // R1 reset again clears everything
        pulse(5'b10011);
        @(negedge clk); quiet(); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd2, 32'h00, "R1 status after reset");
        rd(3'd4, 32'h0, "R1 ptr after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule